// File: doc/BRIEF.md
# Board Control Register Bank

This block is a bank of board control registers on a plain single-cycle register bus. A write strobe with an address and a 32-bit data word updates a register at the next clock edge. Read data is a combinational function of the address and the current register state. Only the low 20 address bits take part in decoding, so the bank appears at every alias of its window.

The bank holds three kinds of register:
- An LED bar byte.
- An eight-character ASCII display buffer. Software can fill it in two ways: one character at a time, or with a single 32-bit word that the bank turns into eight uppercase hexadecimal digits.
- A handful of board bytes: a break/reset byte, a general-purpose output byte, and fixed switch, jumper and status values.

A magic value written to a soft-reset register produces a one-cycle system reset request. Four bit-bang I2C registers drive SCL and SDA towards an attached serial EEPROM. A one-cycle strobe accompanies each write so the slave can sample it. The EEPROM's SDA line comes back in through the I2C input register.

Top module: `board_ctrl_regs`

## Requirements
- R1: Only addr[19:0] is decoded, so any upper address bits select the same register. A read from an unmapped offset (for example 0x404) returns 0, and a write to one changes no register or output.
- R2: The switch register (offset 0x200) and the jumper register (offset 0x210) always read 0, and writes to them change nothing.
- R3: The status register at offset 0x208 reads 0x12 when parameter BIG_ENDIAN is 1 and 0x10 when it is 0.
- R4: A write to offset 0x408 stores wrData[7:0] as the LED byte. The LED byte drives ledBar and reads back at 0x408 in bits [7:0], with the upper bits 0.
- R5: A write to offset 0x410 fills all eight display positions with uppercase hex ASCII ('0'-'9' are 0x30-0x39, 'A'-'F' are 0x41-0x46). Position 0 gets wrData[31:28] and position 7 gets wrData[3:0]. Position i appears on dispText[8i+7:8i].
- R6: A write to offset 0x418 + 8*i, for i from 0 to 7, stores wrData[7:0] at display position i and leaves the other positions unchanged.
- R7: A write of exactly 0x00000042 to offset 0x500 raises sysResetReq for exactly one cycle, in the cycle after the write edge. Any other value leaves sysResetReq low.
- R8: The break byte (offset 0x508, reset value 0x0A) and the general-purpose output byte (offset 0xA00, reset value 0x00) each store wrData[7:0]. They drive brkByte and gpOut and read back at their offsets.
- R9: The I2C output register at offset 0xB10 has SCL in bit 1 and SDA in bit 0, and resets to 0x3. A write updates sclOut and sdaOut, pulses i2cWrPulse for one cycle and reads back as bits [1:0].
- R10: The I2C output-enable register at offset 0xB08 keeps wrData[1:0] (reset 0) and drives i2cOutEn. The select register at offset 0xB18 keeps wrData[0] (reset 1). Both read back at their offsets.
- R11: A read of offset 0xB00 returns the stored input bits (reset value 0x3) with bit 0 replaced by eepSdaIn, which gives 0x2 or 0x3.
- R12: A read of offset 0xA08 returns the I2C output register when the select bit is 1, and 0 when it is 0.
- R13: After reset, every display position holds a space (0x20) and ledBar is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| addr | input | ADDR_W | Register address; bits [19:0] are decoded |
| wrEn | input | 1 | Write strobe for the current cycle |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Combinational read data for addr |
| eepSdaIn | input | 1 | SDA driven back by the EEPROM slave |
| ledBar | output | 8 | LED bar byte |
| dispText | output | 64 | Display buffer; position i on bits [8i+7:8i] |
| sysResetReq | output | 1 | One-cycle system reset request |
| brkByte | output | 8 | Break/reset byte |
| gpOut | output | 8 | General-purpose output byte |
| i2cOutEn | output | 2 | I2C output-enable bits |
| sclOut | output | 1 | I2C clock line towards the EEPROM |
| sdaOut | output | 1 | I2C data line towards the EEPROM |
| i2cWrPulse | output | 1 | One-cycle strobe after each I2C output write |

## Verification
Every register output, including the reset-request and I2C strobes, changes at the clock edge that samples the write, so its result is due one edge after the write. The bench drives each write on a falling edge, lets one rising edge pass, and samples outputs on the next falling edge. At that point the two pulses must be high, and they are sampled again one cycle later to confirm they are low. Read data is combinational, so the bench sets the address on a falling edge and samples rdData a nanosecond later, against the register state left by the previous write.

// File: rtl/board_ctrl_pkg.sv
package board_ctrl_pkg;

  localparam int unsigned DATA_W     = 32;
  localparam int unsigned DEC_W      = 20;
  localparam int unsigned NUM_CHARS  = 8;
  localparam int unsigned CHAR_IDX_W = $clog2(NUM_CHARS);

  // Offsets whose values software depends on
  localparam logic [DEC_W-1:0] OFS_SWITCH  = 20'h00200;
  localparam logic [DEC_W-1:0] OFS_STATUS  = 20'h00208;
  localparam logic [DEC_W-1:0] OFS_JUMPER  = 20'h00210;
  localparam logic [DEC_W-1:0] OFS_LED     = 20'h00408;
  localparam logic [DEC_W-1:0] OFS_WORD    = 20'h00410;
  localparam logic [DEC_W-1:0] OFS_CHAR0   = 20'h00418;
  localparam logic [DEC_W-1:0] OFS_CHARN   = OFS_CHAR0 + DEC_W'(8 * (NUM_CHARS - 1));
  localparam logic [DEC_W-1:0] OFS_SOFTRST = 20'h00500;
  localparam logic [DEC_W-1:0] OFS_BRK     = 20'h00508;
  localparam logic [DEC_W-1:0] OFS_GPO     = 20'h00A00;
  localparam logic [DEC_W-1:0] OFS_GPIN    = 20'h00A08;
  localparam logic [DEC_W-1:0] OFS_I2CIN   = 20'h00B00;
  localparam logic [DEC_W-1:0] OFS_I2COE   = 20'h00B08;
  localparam logic [DEC_W-1:0] OFS_I2COUT  = 20'h00B10;
  localparam logic [DEC_W-1:0] OFS_I2CSEL  = 20'h00B18;

  localparam logic [DATA_W-1:0] SOFTRST_MAGIC = 32'h0000_0042;

  typedef enum logic [3:0] {
    RD_ZERO, RD_STATUS, RD_LED, RD_BRK, RD_GPO,
    RD_GPIN, RD_I2CIN, RD_OE, RD_OUT, RD_SEL
  } rdSel_e;

  typedef struct packed {
    logic                  ledWr;
    logic                  wordWr;
    logic                  charWr;
    logic [CHAR_IDX_W-1:0] charIdx;
    logic                  softRstWr;
    logic                  brkWr;
    logic                  gpoWr;
    logic                  oeWr;
    logic                  outWr;
    logic                  selWr;
  } wrStrobe_t;

  function automatic logic [7:0] hexChar(input logic [3:0] nib);
    return (nib < 4'd10) ? (8'h30 + {4'b0, nib}) : (8'h37 + {4'b0, nib});
  endfunction

endpackage

// File: rtl/board_ctrl_decode.sv
module board_ctrl_decode
  import board_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  output wrStrobe_t         strobe,
  output rdSel_e            rdSel
);

  logic [DEC_W-1:0] ofs;
  logic [DEC_W-1:0] charOfs;
  logic             charHit;

  assign ofs     = addr[DEC_W-1:0];
  assign charOfs = ofs - OFS_CHAR0;
  assign charHit = (ofs >= OFS_CHAR0) && (ofs <= OFS_CHARN) && (ofs[2:0] == 3'b000);

  always_comb begin
    strobe         = '0;
    rdSel          = RD_ZERO;
    strobe.charIdx = charOfs[3 +: CHAR_IDX_W];
    strobe.charWr  = wrEn && charHit;
    case (ofs)
      OFS_STATUS:  rdSel = RD_STATUS;
      OFS_LED:     begin rdSel = RD_LED; strobe.ledWr = wrEn; end
      OFS_WORD:    strobe.wordWr = wrEn;
      OFS_SOFTRST: strobe.softRstWr = wrEn;
      OFS_BRK:     begin rdSel = RD_BRK; strobe.brkWr = wrEn; end
      OFS_GPO:     begin rdSel = RD_GPO; strobe.gpoWr = wrEn; end
      OFS_GPIN:    rdSel = RD_GPIN;
      OFS_I2CIN:   rdSel = RD_I2CIN;
      OFS_I2COE:   begin rdSel = RD_OE; strobe.oeWr = wrEn; end
      OFS_I2COUT:  begin rdSel = RD_OUT; strobe.outWr = wrEn; end
      OFS_I2CSEL:  begin rdSel = RD_SEL; strobe.selWr = wrEn; end
      default:     rdSel = RD_ZERO;
    endcase
  end

endmodule

// File: rtl/board_ctrl_datapath.sv
module board_ctrl_datapath
  import board_ctrl_pkg::*;
#(
  parameter bit BIG_ENDIAN = 1'b1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  wrStrobe_t               strobe,
  input  rdSel_e                  rdSel,
  input  logic [DATA_W-1:0]       wrData,
  input  logic                    eepSdaIn,
  output logic [DATA_W-1:0]       rdData,
  output logic [7:0]              ledBar,
  output logic [8*NUM_CHARS-1:0]  dispText,
  output logic                    sysResetReq,
  output logic [7:0]              brkByte,
  output logic [7:0]              gpOut,
  output logic [1:0]              i2cOutEn,
  output logic                    sclOut,
  output logic                    sdaOut,
  output logic                    i2cWrPulse
);

  localparam logic [7:0] STATUS_VAL = BIG_ENDIAN ? 8'h12 : 8'h10;
  localparam logic [1:0] I2CIN_RST  = 2'b11;
  localparam logic [7:0] BRK_RST    = 8'h0A;
  localparam logic [7:0] SPACE_CHR  = 8'h20;

  logic [7:0] ledQ, brkQ, gpoQ;
  logic [1:0] oeQ, outQ;
  logic       selQ;
  logic [7:0] dispQ [NUM_CHARS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ledQ        <= '0;
      brkQ        <= BRK_RST;
      gpoQ        <= '0;
      oeQ         <= '0;
      outQ        <= 2'b11;
      selQ        <= 1'b1;
      sysResetReq <= 1'b0;
      i2cWrPulse  <= 1'b0;
    end else begin
      if (strobe.ledWr) ledQ <= wrData[7:0];
      if (strobe.brkWr) brkQ <= wrData[7:0];
      if (strobe.gpoWr) gpoQ <= wrData[7:0];
      if (strobe.oeWr)  oeQ  <= wrData[1:0];
      if (strobe.outWr) outQ <= wrData[1:0];
      if (strobe.selWr) selQ <= wrData[0];
      sysResetReq <= strobe.softRstWr && (wrData == SOFTRST_MAGIC);
      i2cWrPulse  <= strobe.outWr;
    end
  end

  for (genvar g = 0; g < NUM_CHARS; g++) begin : g_char
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        dispQ[g] <= SPACE_CHR;
      else if (strobe.wordWr)
        dispQ[g] <= hexChar(wrData[DATA_W-1-4*g -: 4]);
      else if (strobe.charWr && (strobe.charIdx == CHAR_IDX_W'(g)))
        dispQ[g] <= wrData[7:0];
    end
    assign dispText[8*g +: 8] = dispQ[g];
  end

  always_comb begin
    rdData = '0;
    case (rdSel)
      RD_STATUS: rdData[7:0] = STATUS_VAL;
      RD_LED:    rdData[7:0] = ledQ;
      RD_BRK:    rdData[7:0] = brkQ;
      RD_GPO:    rdData[7:0] = gpoQ;
      RD_GPIN:   rdData[1:0] = selQ ? outQ : 2'b00;
      RD_I2CIN:  rdData[1:0] = {I2CIN_RST[1], eepSdaIn};
      RD_OE:     rdData[1:0] = oeQ;
      RD_OUT:    rdData[1:0] = outQ;
      RD_SEL:    rdData[0]   = selQ;
      default:   rdData = '0;
    endcase
  end

  assign ledBar   = ledQ;
  assign brkByte  = brkQ;
  assign gpOut    = gpoQ;
  assign i2cOutEn = oeQ;
  assign sclOut   = outQ[1];
  assign sdaOut   = outQ[0];

endmodule

// File: rtl/board_ctrl_regs.sv
module board_ctrl_regs
  import board_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter bit          BIG_ENDIAN = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  input  logic              eepSdaIn,
  output logic [7:0]        ledBar,
  output logic [63:0]       dispText,
  output logic              sysResetReq,
  output logic [7:0]        brkByte,
  output logic [7:0]        gpOut,
  output logic [1:0]        i2cOutEn,
  output logic              sclOut,
  output logic              sdaOut,
  output logic              i2cWrPulse
);

  wrStrobe_t strobe;
  rdSel_e    rdSel;

  board_ctrl_decode #(.ADDR_W(ADDR_W)) decode_i (
    .addr   (addr),
    .wrEn   (wrEn),
    .strobe (strobe),
    .rdSel  (rdSel)
  );

  board_ctrl_datapath #(.BIG_ENDIAN(BIG_ENDIAN)) datapath_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .rdSel       (rdSel),
    .wrData      (wrData),
    .eepSdaIn    (eepSdaIn),
    .rdData      (rdData),
    .ledBar      (ledBar),
    .dispText    (dispText),
    .sysResetReq (sysResetReq),
    .brkByte     (brkByte),
    .gpOut       (gpOut),
    .i2cOutEn    (i2cOutEn),
    .sclOut      (sclOut),
    .sdaOut      (sdaOut),
    .i2cWrPulse  (i2cWrPulse)
  );

endmodule

// File: rtl/board_ctrl_regs_chk.sv
module board_ctrl_regs_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] addr,
  input logic              wrEn,
  input logic [31:0]       wrData,
  input logic [31:0]       rdData,
  input logic              eepSdaIn,
  input logic [7:0]        ledBar,
  input logic [63:0]       dispText,
  input logic              sysResetReq,
  input logic [1:0]        i2cOutEn,
  input logic              sclOut,
  input logic              sdaOut,
  input logic              i2cWrPulse
);

  logic [19:0] ofs;
  logic        readsZero;
  assign ofs = addr[19:0];
  // Offsets that never return data
  assign readsZero = (ofs == 20'h00200) || (ofs == 20'h00210) || (ofs == 20'h00404) ||
                     (ofs == 20'h00410) || (ofs == 20'h00500);

  function automatic logic [7:0] expHex(input logic [3:0] n);
    return (n < 4'd10) ? (8'h30 + {4'b0, n}) : (8'h41 + {4'b0, n} - 8'd10);
  endfunction

  // R1, R2
  a_r1_zero_reads: assert property (@(posedge clk) disable iff (!rstN)
    readsZero |-> (rdData == 32'h0));

  // R4
  a_r4_led_write: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && ofs == 20'h00408) |=> (ledBar == $past(wrData[7:0])));

  // R5
  a_r5_word_hex: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && ofs == 20'h00410) |=>
      (dispText[7:0] == expHex($past(wrData[31:28]))) &&
      (dispText[63:56] == expHex($past(wrData[3:0]))));

  // R7
  a_r7_reset_cause: assert property (@(posedge clk) disable iff (!rstN)
    sysResetReq |-> $past(wrEn && ofs == 20'h00500 && wrData == 32'h42));

  // R9
  a_r9_i2c_drive: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && ofs == 20'h00B10) |=>
      (i2cWrPulse && {sclOut, sdaOut} == $past(wrData[1:0])));

  a_r9_pulse_cause: assert property (@(posedge clk) disable iff (!rstN)
    i2cWrPulse |-> $past(wrEn && ofs == 20'h00B10));

  // R10
  a_r10_oe_write: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && ofs == 20'h00B08) |=> (i2cOutEn == $past(wrData[1:0])));

  // R11
  a_r11_sda_return: assert property (@(posedge clk) disable iff (!rstN)
    (ofs == 20'h00B00) |-> (rdData == {30'b0, 1'b1, eepSdaIn}));

endmodule

bind board_ctrl_regs board_ctrl_regs_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .addr        (addr),
  .wrEn        (wrEn),
  .wrData      (wrData),
  .rdData      (rdData),
  .eepSdaIn    (eepSdaIn),
  .ledBar      (ledBar),
  .dispText    (dispText),
  .sysResetReq (sysResetReq),
  .i2cOutEn    (i2cOutEn),
  .sclOut      (sclOut),
  .sdaOut      (sdaOut),
  .i2cWrPulse  (i2cWrPulse)
);

// File: tb/board_ctrl_regs_tb.sv
module board_ctrl_regs_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] addr = '0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        eepSdaIn = 1'b1;
  logic [7:0]  ledBar, brkByte, gpOut;
  logic [63:0] dispText;
  logic        sysResetReq, sclOut, sdaOut, i2cWrPulse;
  logic [1:0]  i2cOutEn;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [7:0]  mLed, mBrk, mGpo;
  logic [63:0] mDisp;
  logic [1:0]  mOut, mOe;
  logic        mSel;

  always #2 clk = ~clk;

  board_ctrl_regs dut_i (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .eepSdaIn(eepSdaIn), .ledBar(ledBar), .dispText(dispText),
    .sysResetReq(sysResetReq), .brkByte(brkByte), .gpOut(gpOut),
    .i2cOutEn(i2cOutEn), .sclOut(sclOut), .sdaOut(sdaOut), .i2cWrPulse(i2cWrPulse)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] hexText(input logic [31:0] w);
    logic [63:0] t;
    for (int i = 0; i < 8; i++) begin
      logic [3:0] n;
      n = w[31-4*i -: 4];
      t[8*i +: 8] = (n < 10) ? (8'd48 + 8'(n)) : (8'd65 + 8'(n) - 8'd10);
    end
    return t;
  endfunction

  task automatic doWrite(input logic [19:0] ofs, input logic [31:0] d, input logic [11:0] hi = 12'h1F0);
    @(negedge clk);
    addr = {hi, ofs}; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; addr = 32'h0000_0004;
  endtask

  task automatic readReg(input logic [19:0] ofs, output logic [31:0] d);
    @(negedge clk);
    addr = {12'hABC, ofs};
    #1 d = rdData;
  endtask

  task automatic checkAll(input string req);
    logic [31:0] r;
    check({req, " ledBar"}, 64'(ledBar), 64'(mLed));
    check({req, " dispText"}, dispText, mDisp);
    check({req, " brkByte"}, 64'(brkByte), 64'(mBrk));
    check({req, " gpOut"}, 64'(gpOut), 64'(mGpo));
    check({req, " scl/sda"}, 64'({sclOut, sdaOut}), 64'(mOut));
    readReg(20'h00408, r); check({req, " LED read"}, 64'(r), 64'(mLed));
    readReg(20'h00A08, r); check({req, " R12 GPINP"}, 64'(r), mSel ? 64'(mOut) : 64'h0);
    readReg(20'h00B18, r); check({req, " R10 select read"}, 64'(r), 64'(mSel));
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    mLed = 8'h00; mBrk = 8'h0A; mGpo = 8'h00; mDisp = {8{8'h20}};
    mOut = 2'b11; mOe = 2'b00; mSel = 1'b1;

    // R13 reset state, R8/R9/R10 reset values
    check("R13 reset display", dispText, 64'h2020202020202020);
    check("R13 reset led", 64'(ledBar), 64'h0);
    check("R8 reset brk", 64'(brkByte), 64'h0A);
    check("R8 reset gpo", 64'(gpOut), 64'h0);
    check("R9 reset scl/sda", 64'({sclOut, sdaOut}), 64'h3);
    check("R10 reset oe", 64'(i2cOutEn), 64'h0);
    checkAll("R13 reset");

    // R3 status, R2 switches/jumpers
    readReg(20'h00208, r); check("R3 status", 64'(r), 64'h12);
    readReg(20'h00200, r); check("R2 switches", 64'(r), 64'h0);
    readReg(20'h00210, r); check("R2 jumpers", 64'(r), 64'h0);

    // R11 I2C input with EEPROM SDA
    eepSdaIn = 1'b0; readReg(20'h00B00, r); check("R11 sda low", 64'(r), 64'h2);
    eepSdaIn = 1'b1; readReg(20'h00B00, r); check("R11 sda high", 64'(r), 64'h3);

    // R2 and R1 ignored writes
    doWrite(20'h00200, 32'hFFFF_FFFF); doWrite(20'h00210, 32'hFFFF_FFFF);
    readReg(20'h00200, r); check("R2 switch after write", 64'(r), 64'h0);
    doWrite(20'h00404, 32'h0000_00FF);
    readReg(20'h00404, r); check("R1 unmapped read", 64'(r), 64'h0);
    checkAll("R1 unmapped write");

    // R5 word write
    doWrite(20'h00410, 32'hDEAD_BEEF); mDisp = hexText(32'hDEAD_BEEF);
    check("R5 word DEADBEEF", dispText, mDisp);
    doWrite(20'h00410, 32'h0123_4567); mDisp = hexText(32'h0123_4567);
    check("R5 word 01234567", dispText, mDisp);

    // R6 char writes at first and last positions
    doWrite(20'h00418, 32'h0000_1241); mDisp[7:0] = 8'h41;
    doWrite(20'h00450, 32'h0000_007A); mDisp[63:56] = 8'h7A;
    check("R6 char ends", dispText, mDisp);

    // R7 reset request
    doWrite(20'h00500, 32'h42);
    check("R7 pulse high", 64'(sysResetReq), 64'h1);
    @(negedge clk); check("R7 pulse one cycle", 64'(sysResetReq), 64'h0);
    doWrite(20'h00500, 32'h43);
    check("R7 wrong value", 64'(sysResetReq), 64'h0);
    doWrite(20'h00500, 32'h142);
    check("R7 upper bits set", 64'(sysResetReq), 64'h0);

    // R9 pulse, R10 oe width, R12 select off
    doWrite(20'h00B10, 32'hFFFF_FFFE); mOut = 2'b10;
    check("R9 write pulse", 64'(i2cWrPulse), 64'h1);
    @(negedge clk); check("R9 pulse one cycle", 64'(i2cWrPulse), 64'h0);
    doWrite(20'h00B08, 32'hFF); mOe = 2'b11;
    check("R10 oe", 64'(i2cOutEn), 64'h3);
    readReg(20'h00B08, r); check("R10 oe read", 64'(r), 64'h3);
    doWrite(20'h00B18, 32'h2); mSel = 1'b0;
    checkAll("R12 select off");

    // Random mix
    for (int it = 0; it < 300; it++) begin
      logic [31:0] d;
      logic [11:0] hi;
      int op;
      d  = $urandom;
      hi = 12'($urandom);
      op = $urandom_range(0, 6);
      case (op)
        0: begin doWrite(20'h00408, d, hi); mLed = d[7:0]; end
        1: begin doWrite(20'h00410, d, hi); mDisp = hexText(d); end
        2: begin
             int k;
             k = $urandom_range(0, 7);
             doWrite(20'h00418 + 20'(8 * k), d, hi); mDisp[8*k +: 8] = d[7:0];
           end
        3: begin doWrite(20'h00508, d, hi); mBrk = d[7:0]; end
        4: begin doWrite(20'h00A00, d, hi); mGpo = d[7:0]; end
        5: begin doWrite(20'h00B10, d, hi); mOut = d[1:0]; end
        default: begin doWrite(20'h00B18, d, hi); mSel = d[0]; end
      endcase
      if (it % 10 == 9) checkAll("R4 R6 R8 R9 R12 random");
      else begin
        check("R5 R6 random display", dispText, mDisp);
        check("R4 random led", 64'(ledBar), 64'(mLed));
      end
    end
    readReg(20'h00508, r); check("R8 brk read", 64'(r), 64'(mBrk));
    readReg(20'h00A00, r); check("R8 gpo read", 64'(r), 64'(mGpo));
    readReg(20'h00B10, r); check("R9 out read", 64'(r), 64'(mOut));

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule